// File: doc/BRIEF.md
# Debug Event Capture for Taken Branches and Instruction Completion

This unit sits beside the retirement stage of a simple in-order core. It watches one retiring instruction per cycle and raises two kinds of debug event: a taken-branch event and an instruction-complete event. Each event needs the global debug-interrupt enable and its own control bit. When an event fires, the unit sets a sticky status bit that software clears by writing a one. It also requests a debug interrupt and saves a return address for the critical save/restore register.

A taken-branch event stops the branch from executing, so its return address is the branch itself. A completion event lets the instruction finish, so its return address is the following word. Events that arrive while the global enable is clear are discarded outright. They leave no status behind and cause no deferred interrupt later. The interrupt request and the return address are registered. They stay put until the core acknowledges the interrupt.

Top module: `dbg_event_unit`

## Requirements
- R1: A taken-branch event fires when `ins_valid`, `dbg_en`, `ctl_brt_en`, `ins_branch` and `ins_taken` are all high. `suppress` is high in that same cycle, and status bit 0 (`sts[0]`) is set at the next clock edge. Unconditional branches are presented with `ins_taken` high.
- R2: An instruction-complete event fires when `ins_valid`, `dbg_en` and `ctl_icmp_en` are high for a completing instruction. It sets status bit 1 (`sts[1]`) at the next edge.
- R3: While `dbg_en` is low, neither event fires. `suppress` stays low, `sts` is unchanged and no interrupt is requested, even after `dbg_en` returns high.
- R4: A taken-branch event that reaches the interrupt loads `ret_addr` with the branch's own word-aligned address (`ins_pc` with bits 1:0 forced to 0).
- R5: A completion event that reaches the interrupt loads `ret_addr` with the aligned address plus 4, wrapping modulo 2^32.
- R6: `dbg_irq` rises at the next edge after an event, unless `hi_pri_exc` is high in the event cycle. In that case no interrupt is raised and `ret_addr` is untouched, but the status bit and `suppress` still follow R1/R2.
- R7: An instruction with `ins_xsupp` high (killed by another exception) and `ins_syscall` low raises no completion event.
- R8: A system call (`ins_syscall` high) counts as completing even when `ins_xsupp` is high, and raises a completion event.
- R9: When a taken branch qualifies for both events, only the taken-branch event fires: `sts[0]` is set, `sts[1]` is not, and the return address is the branch's own address. An untaken branch can still raise a completion event.
- R10: Status bits stay set until a cycle with `sts_wr` high writes a one to the matching bit of `sts_wdata`. If an event for that bit occurs in the same cycle, the bit stays set.
- R11: `dbg_irq` and `ret_addr` hold until `irq_ack`. A new event that arrives while a request is pending and unacknowledged does not change `ret_addr`. An event in the same cycle as `irq_ack` starts a new request with its own address.
- R12: After reset, `sts` is 0, `dbg_irq` is 0 and `ret_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_en | input | 1 | Global debug-interrupt enable |
| ctl_brt_en | input | 1 | Taken-branch event enable |
| ctl_icmp_en | input | 1 | Instruction-complete event enable |
| ins_valid | input | 1 | A retiring instruction is present |
| ins_branch | input | 1 | Instruction is a branch |
| ins_taken | input | 1 | Branch direction is taken |
| ins_xsupp | input | 1 | Instruction was suppressed by another exception |
| ins_syscall | input | 1 | Instruction is a system call |
| ins_pc | input | AW | Instruction address |
| hi_pri_exc | input | 1 | A higher-priority exception has taken the interrupt |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 2 | Write-one-to-clear mask for `sts` |
| irq_ack | input | 1 | Debug interrupt acknowledge |
| sts | output | 2 | Sticky status: bit 0 taken branch, bit 1 complete |
| dbg_irq | output | 1 | Debug interrupt request |
| suppress | output | 1 | Suppress the current instruction |
| ret_addr | output | AW | Saved return address |

## Verification
The bench goes after the cases where the two events overlap. If a taken branch with both enables set also logged a completion, `sts` would read 3 instead of 1 and the return address would point one word past the branch. A system call flagged as exception-killed must still complete. If the bench disables events, re-enables them and then finds nonzero status, the design has logged dropped events for later delivery. Two more cases catch mishandled timing: a clear in the same cycle as a new event, and a second event while an interrupt is still pending. Getting these wrong shows up as a lost status bit or an overwritten return address.

// File: rtl/dbg_event_unit.sv
module dbg_event_unit #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dbg_en,
  input  logic          ctl_brt_en,
  input  logic          ctl_icmp_en,
  input  logic          ins_valid,
  input  logic          ins_branch,
  input  logic          ins_taken,
  input  logic          ins_xsupp,
  input  logic          ins_syscall,
  input  logic [AW-1:0] ins_pc,
  input  logic          hi_pri_exc,
  input  logic          sts_wr,
  input  logic [1:0]    sts_wdata,
  input  logic          irq_ack,
  output logic [1:0]    sts,
  output logic          dbg_irq,
  output logic          suppress,
  output logic [AW-1:0] ret_addr
);
  localparam logic [AW-1:0] WORD = AW'(4);

  logic          brt_hit, icmp_hit, fire, take;
  logic [AW-1:0] pc_al, tgt;
  logic [1:0]    clr;

  assign pc_al    = {ins_pc[AW-1:2], 2'b00};
  assign brt_hit  = ins_valid & dbg_en & ctl_brt_en & ins_branch & ins_taken;
  assign icmp_hit = ins_valid & dbg_en & ctl_icmp_en & ~brt_hit
                  & (~ins_xsupp | ins_syscall);
  assign fire     = (brt_hit | icmp_hit) & ~hi_pri_exc;
  assign take     = fire & (~dbg_irq | irq_ack);
  assign tgt      = brt_hit ? pc_al : pc_al + WORD;
  assign clr      = sts_wr ? sts_wdata : 2'b00;
  assign suppress = brt_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts      <= 2'b00;
      dbg_irq  <= 1'b0;
      ret_addr <= '0;
    end else begin
      sts     <= (sts & ~clr) | {icmp_hit, brt_hit};
      dbg_irq <= fire | (dbg_irq & ~irq_ack);
      if (take) ret_addr <= tgt;
    end
  end
endmodule

module dbg_event_unit_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dbg_en,
  input logic          ctl_icmp_en,
  input logic          ins_valid,
  input logic          ins_branch,
  input logic          ins_taken,
  input logic          ins_xsupp,
  input logic          ins_syscall,
  input logic [AW-1:0] ins_pc,
  input logic          hi_pri_exc,
  input logic          sts_wr,
  input logic [1:0]    sts_wdata,
  input logic          irq_ack,
  input logic [1:0]    sts,
  input logic          dbg_irq,
  input logic          suppress,
  input logic [AW-1:0] ret_addr
);
  a_r1_suppress_qual: assert property (@(posedge clk) disable iff (!rst_n)
    suppress |-> (ins_valid && dbg_en && ins_branch && ins_taken));

  a_r1_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    suppress |=> sts[0]);

  a_r3_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_en && !sts_wr) |=> $stable(sts));

  a_r4_branch_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (suppress && !hi_pri_exc && (!dbg_irq || irq_ack)) |=>
      (dbg_irq && ret_addr == {$past(ins_pc[AW-1:2]), 2'b00}));

  a_r5_next_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && dbg_en && ctl_icmp_en && !ins_branch && !ins_xsupp &&
     !hi_pri_exc && !dbg_irq) |=>
      (dbg_irq && ret_addr == {$past(ins_pc[AW-1:2]), 2'b00} + AW'(4)));

  a_r7_killed_no_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_xsupp && !ins_syscall && !sts[1]) |=> !sts[1]);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[0] && !(sts_wr && sts_wdata[0])) |=> sts[0]);

  a_r11_hold_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_irq && !irq_ack) |=> (dbg_irq && $stable(ret_addr)));
endmodule

bind dbg_event_unit dbg_event_unit_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .ctl_icmp_en(ctl_icmp_en),
  .ins_valid(ins_valid), .ins_branch(ins_branch), .ins_taken(ins_taken),
  .ins_xsupp(ins_xsupp), .ins_syscall(ins_syscall), .ins_pc(ins_pc),
  .hi_pri_exc(hi_pri_exc), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
  .irq_ack(irq_ack), .sts(sts), .dbg_irq(dbg_irq), .suppress(suppress),
  .ret_addr(ret_addr)
);

// File: tb/sim_dbg_event_unit.sv
module sim_dbg_event_unit;
  logic clk = 0, rst_n = 0;
  logic dbg_en = 0, ctl_brt_en = 0, ctl_icmp_en = 0;
  logic ins_valid = 0, ins_branch = 0, ins_taken = 0, ins_xsupp = 0, ins_syscall = 0;
  logic [31:0] ins_pc = 0;
  logic hi_pri_exc = 0, sts_wr = 0, irq_ack = 0;
  logic [1:0] sts_wdata = 0;
  logic [1:0] sts;
  logic dbg_irq, suppress;
  logic [31:0] ret_addr;

  int vectors = 0, errors = 0;
  bit done = 0;
  logic [1:0] m_sts;
  logic m_irq;
  logic [31:0] m_ret;

  always #2.5 clk = ~clk;

  dbg_event_unit u0 (
    .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .ctl_brt_en(ctl_brt_en),
    .ctl_icmp_en(ctl_icmp_en), .ins_valid(ins_valid), .ins_branch(ins_branch),
    .ins_taken(ins_taken), .ins_xsupp(ins_xsupp), .ins_syscall(ins_syscall),
    .ins_pc(ins_pc), .hi_pri_exc(hi_pri_exc), .sts_wr(sts_wr),
    .sts_wdata(sts_wdata), .irq_ack(irq_ack), .sts(sts), .dbg_irq(dbg_irq),
    .suppress(suppress), .ret_addr(ret_addr));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic enables(input bit g, input bit b, input bit c);
    dbg_en = g; ctl_brt_en = b; ctl_icmp_en = c;
  endtask

  task automatic apply(input bit v, input bit br, input bit tk, input bit xs,
                       input bit sc, input logic [31:0] pc, input bit hp,
                       input bit wr, input logic [1:0] wd, input bit ack,
                       input string tag);
    bit eb, ei, f;
    logic [31:0] al;
    ins_valid = v; ins_branch = br; ins_taken = tk; ins_xsupp = xs;
    ins_syscall = sc; ins_pc = pc; hi_pri_exc = hp; sts_wr = wr;
    sts_wdata = wd; irq_ack = ack;
    #1;
    eb = v && dbg_en && ctl_brt_en && br && tk;
    ei = v && dbg_en && ctl_icmp_en && !eb && (!xs || sc);
    f  = (eb || ei) && !hp;
    al = {pc[31:2], 2'b00};
    check({tag, " suppress"}, {31'd0, suppress}, {31'd0, eb});
    if (f && (!m_irq || ack)) m_ret = eb ? al : al + 32'd4;
    m_irq = f || (m_irq && !ack);
    m_sts = (m_sts & ~(wr ? wd : 2'b00)) | {ei, eb};
    @(negedge clk); #1;
    check({tag, " sts"}, {30'd0, sts}, {30'd0, m_sts});
    check({tag, " irq"}, {31'd0, dbg_irq}, {31'd0, m_irq});
    check({tag, " ret_addr"}, ret_addr, m_ret);
    ins_valid = 0; sts_wr = 0; irq_ack = 0; hi_pri_exc = 0;
  endtask

  task automatic idle_clear(input string tag);
    apply(0, 0, 0, 0, 0, 0, 0, 1, 2'b11, 1, tag);
  endtask

  task automatic t_reset;
    check("R12 reset sts", {30'd0, sts}, 0);
    check("R12 reset irq", {31'd0, dbg_irq}, 0);
    check("R12 reset ret_addr", ret_addr, 0);
  endtask

  task automatic t_branch;
    enables(1, 1, 0);
    apply(1, 1, 1, 0, 0, 32'h0000_0100, 0, 0, 0, 0, "R1 R4 taken branch");
    idle_clear("R1 clear");
    apply(1, 1, 1, 0, 0, 32'h0000_0343, 0, 0, 0, 0, "R4 unaligned pc");
    idle_clear("R4 clear");
    apply(1, 1, 0, 0, 0, 32'h0000_0400, 0, 0, 0, 0, "R1 untaken no event");
  endtask

  task automatic t_complete;
    enables(1, 0, 1);
    apply(1, 0, 0, 0, 0, 32'h0000_0200, 0, 0, 0, 0, "R2 R5 complete");
    idle_clear("R2 clear");
    apply(1, 0, 0, 0, 0, 32'hFFFF_FFFC, 0, 0, 0, 0, "R5 wrap");
    idle_clear("R5 clear");
  endtask

  task automatic t_disable;
    enables(0, 1, 1);
    apply(1, 1, 1, 0, 0, 32'h0000_0500, 0, 0, 0, 0, "R3 branch off");
    apply(1, 0, 0, 0, 0, 32'h0000_0504, 0, 0, 0, 0, "R3 insn off");
    enables(1, 1, 1);
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 re-enable no backlog");
  endtask

  task automatic t_hipri;
    enables(1, 1, 1);
    apply(1, 1, 1, 0, 0, 32'h0000_0600, 1, 0, 0, 0, "R6 branch hipri");
    apply(1, 0, 0, 0, 0, 32'h0000_0700, 1, 0, 0, 0, "R6 cmp hipri");
    idle_clear("R6 clear");
  endtask

  task automatic t_killed;
    enables(1, 0, 1);
    apply(1, 0, 0, 1, 0, 32'h0000_0800, 0, 0, 0, 0, "R7 killed insn");
    apply(1, 0, 0, 1, 1, 32'h0000_0900, 0, 0, 0, 0, "R8 syscall completes");
    idle_clear("R8 clear");
  endtask

  task automatic t_both;
    enables(1, 1, 1);
    apply(1, 1, 1, 0, 0, 32'h0000_0A00, 0, 0, 0, 0, "R9 branch wins");
    idle_clear("R9 clear");
    apply(1, 1, 0, 0, 0, 32'h0000_0B00, 0, 0, 0, 0, "R9 untaken completes");
    idle_clear("R9 clear2");
  endtask

  task automatic t_w1c;
    enables(1, 1, 1);
    apply(1, 1, 1, 0, 0, 32'h0000_0C00, 0, 0, 0, 1, "R10 set bit0");
    apply(1, 0, 0, 0, 0, 32'h0000_0C04, 0, 0, 0, 1, "R10 set bit1");
    apply(1, 1, 1, 0, 0, 32'h0000_0C08, 0, 1, 2'b01, 1, "R10 clear vs event");
    apply(0, 0, 0, 0, 0, 0, 0, 1, 2'b10, 1, "R10 clear bit1 only");
    idle_clear("R10 clear all");
  endtask

  task automatic t_hold;
    enables(1, 1, 1);
    apply(1, 0, 0, 0, 0, 32'h0000_1000, 0, 0, 0, 0, "R11 first event");
    apply(1, 1, 1, 0, 0, 32'h0000_2000, 0, 0, 0, 0, "R11 second held");
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11 idle held");
    apply(1, 1, 1, 0, 0, 32'h0000_3000, 0, 0, 0, 1, "R11 ack with event");
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R11 ack drops");
    idle_clear("R11 clear");
  endtask

  task automatic t_random;
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      enables(r[0] | r[1], r[2], r[3]);
      apply(r[4] | r[5], r[6], r[7], r[8] & r[9], r[10] & r[11],
            {$urandom} & 32'hFFFF_FFFC, r[12] & r[13] & r[14], r[15] & r[16],
            r[18:17], r[19] & r[20], "R1-model random");
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    m_sts = 0; m_irq = 0; m_ret = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    t_reset();
    t_branch();
    t_complete();
    t_disable();
    t_hipri();
    t_killed();
    t_both();
    t_w1c();
    t_hold();
    t_random();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule